// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block converts single-word read and write requests from an on-chip host into cycles on an asynchronous external memory bus. The bus has a 16-bit data path, split into separate output, input and output-enable signals, a 22-bit word address, a 2-bit bank address and two active-low chip selects. It also has active-low write-enable and output-enable strobes. Every access passes through three phases in a fixed order: setup, then strobe, then hold. Reads and writes each have their own cycle counts for these phases. A programmable turnaround gap follows every access before the next request can be taken.

A slow device can stretch the strobe phase by driving the active-low wait input. The wait input passes through a two-stage synchronizer. It only has an effect if it is seen early enough, at least four cycles before the point where the strobe would end without extension. Once an extension starts, it lasts until wait is released. A programmable ceiling bounds the extension. When the ceiling is reached, the access still runs its hold phase, and a timeout flag is raised together with the done pulse. All timing fields are static configuration inputs. Each field holds the desired cycle count minus one.

Top module: `amc_ctrl`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of an access, the outputs return to the idle state: both chip selects high, both strobes high, data output enable low, `req_ready` high and `done` low.
- R2: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle, the chip select picked by `req_cs` is low (bit `req_cs` of `mem_cs_n`), and `mem_addr` and `mem_ba` carry the request's values. The setup phase then lasts (setup field + 1) cycles with both strobes high. The read or write setup field is chosen by `req_write` (1 = write).
- R3: The strobe phase lasts (strobe field + 1) cycles when it is not extended. During it, `mem_oe_n` is low for a read and `mem_we_n` is low for a write. The other strobe stays high throughout.
- R4: The hold phase lasts (hold field + 1) cycles. The chip select stays low and both strobes are high.
- R5: `done` is high for exactly one cycle, the first cycle after hold. `req_ready` is low from that cycle for (turnaround field + 1) cycles and high afterwards.
- R6: For a read, `done_rdata` holds the value of `mem_data_i` in the last cycle in which `mem_oe_n` is low.
- R7: `mem_data_oe` is high exactly while a write's chip select is low, from the start of setup to the end of hold, and `mem_data_o` then carries the write data. `mem_data_oe` is low during reads and when idle.
- R8: `mem_wait_n` is synchronized by two registers. It arms an extension only if its synchronized low value is seen in a strobe cycle with index at most (strobe field − 3), counting the first strobe cycle as index 0. Wait that arrives later, or with a strobe field below 3, has no effect.
- R9: If the access is armed and the synchronized wait is still low in the last unextended strobe cycle, the strobe continues. It ends with the first cycle in which the synchronized wait is high, and that cycle is included.
- R10: An extension lasts at most (wait-max field + 1) cycles. If the ceiling ends the extension, `done_timeout` is high together with `done`. Otherwise `done_timeout` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_setup | input | 4 | Read setup cycles minus one |
| cfg_rd_strobe | input | 6 | Read strobe cycles minus one |
| cfg_rd_hold | input | 3 | Read hold cycles minus one |
| cfg_wr_setup | input | 4 | Write setup cycles minus one |
| cfg_wr_strobe | input | 6 | Write strobe cycles minus one |
| cfg_wr_hold | input | 3 | Write hold cycles minus one |
| cfg_turn | input | 2 | Turnaround cycles minus one |
| cfg_wait_max | input | 8 | Extension ceiling minus one |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 1 | Index of the chip select to drive |
| req_ba | input | 2 | Bank address |
| req_addr | input | 22 | Word address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 16 | Read data, valid with done |
| done_timeout | output | 1 | Wait ceiling reached, valid with done |
| mem_cs_n | output | 2 | Active-low chip selects |
| mem_ba | output | 2 | Bank address to memory |
| mem_addr | output | 22 | Address to memory |
| mem_data_o | output | 16 | Data driven to memory |
| mem_data_i | input | 16 | Data returned by memory |
| mem_data_oe | output | 1 | Data bus drive enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output-enable strobe |
| mem_wait_n | input | 1 | Active-low wait from memory |

## Verification
The hardest cases are the edges of the wait arming window. These are wait that arrives exactly one cycle too late to arm, and wait that arrives exactly on the last cycle that still arms. The two-stage synchronizer latency makes both easy to miss by one cycle. The stimulus drives `mem_wait_n` on falling edges at a strobe-relative cycle index, computed from the setup length. Vectors place the assertion and release points on both sides of the window, keep wait low through the strobe so that the ceiling is reached, and use a strobe too short ever to arm. A changing pattern on `mem_data_i` shows in which cycle the read data was captured.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_EXTW, ST_HOLD, ST_TURN
  } amc_state_e;

  // chip select is driven from setup through hold
  function automatic logic in_access(amc_state_e s);
    return (s == ST_SETUP) || (s == ST_STROBE) || (s == ST_EXTW) || (s == ST_HOLD);
  endfunction

  // strobe is low in the nominal and the extended strobe
  function automatic logic in_strobe(amc_state_e s);
    return (s == ST_STROBE) || (s == ST_EXTW);
  endfunction

  // remaining nominal strobe cycles after this one are cnt; window needs cnt+1 >= lead
  function automatic logic early_enough(int unsigned cnt, int unsigned lead);
    return (cnt + 1) >= lead;
  endfunction

endpackage

// File: rtl/amc_sync.sv
module amc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int CNTW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CNTW-1:0] setup_len,
  input  logic [CNTW-1:0] strobe_len,
  input  logic [CNTW-1:0] hold_len,
  input  logic [CNTW-1:0] turn_len,
  input  logic            ext_go,
  input  logic            ext_done,
  output amc_state_e      state,
  output logic [CNTW-1:0] cnt,
  output logic            strobe_last,
  output logic            hold_last
);
  logic cnt_zero;
  assign cnt_zero    = (cnt == '0);
  assign strobe_last = (state == ST_STROBE) && cnt_zero;
  assign hold_last   = (state == ST_HOLD) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (start) begin state <= ST_SETUP; cnt <= setup_len; end
        ST_SETUP:
          if (cnt_zero) begin state <= ST_STROBE; cnt <= strobe_len; end
          else cnt <= cnt - CNTW'(1);
        ST_STROBE:
          if (cnt_zero) begin
            if (ext_go) state <= ST_EXTW;
            else begin state <= ST_HOLD; cnt <= hold_len; end
          end else cnt <= cnt - CNTW'(1);
        ST_EXTW:
          if (ext_done) begin state <= ST_HOLD; cnt <= hold_len; end
        ST_HOLD:
          if (cnt_zero) begin state <= ST_TURN; cnt <= turn_len; end
          else cnt <= cnt - CNTW'(1);
        ST_TURN:
          if (cnt_zero) state <= ST_IDLE;
          else cnt <= cnt - CNTW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amc_wait.sv
module amc_wait
  import amc_pkg::*;
#(
  parameter int CNTW = 6,
  parameter int MWW  = 8,
  parameter int LEAD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ws,
  input  amc_state_e      state,
  input  logic [CNTW-1:0] cnt,
  input  logic            strobe_last,
  input  logic [MWW-1:0]  wait_max,
  output logic            armed,
  output logic            ext_go,
  output logic            ext_done,
  output logic            ext_timeout
);
  logic [MWW-1:0] wcnt_q;
  logic           at_ceiling;

  assign at_ceiling  = (wcnt_q == wait_max);
  assign ext_go      = strobe_last && armed && ws;
  assign ext_done    = (state == ST_EXTW) && (!ws || at_ceiling);
  assign ext_timeout = (state == ST_EXTW) && ws && at_ceiling;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      if (start) armed <= 1'b0;
      else if ((state == ST_STROBE) && ws && early_enough(int'(cnt), LEAD)) armed <= 1'b1;
      if (ext_go) wcnt_q <= '0;
      else if ((state == ST_EXTW) && ws && !at_ceiling) wcnt_q <= wcnt_q + MWW'(1);
    end
  end
endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
  import amc_pkg::*;
#(
  parameter int AW          = 22,
  parameter int DW          = 16,
  parameter int BW          = 2,
  parameter int NCS         = 2,
  parameter int SETW        = 4,
  parameter int STBW        = 6,
  parameter int HLDW        = 3,
  parameter int TAW         = 2,
  parameter int MWW         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_LEAD   = 4,
  localparam int CSW        = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SETW-1:0] cfg_rd_setup,
  input  logic [STBW-1:0] cfg_rd_strobe,
  input  logic [HLDW-1:0] cfg_rd_hold,
  input  logic [SETW-1:0] cfg_wr_setup,
  input  logic [STBW-1:0] cfg_wr_strobe,
  input  logic [HLDW-1:0] cfg_wr_hold,
  input  logic [TAW-1:0]  cfg_turn,
  input  logic [MWW-1:0]  cfg_wait_max,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [CSW-1:0]  req_cs,
  input  logic [BW-1:0]   req_ba,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            done,
  output logic [DW-1:0]   done_rdata,
  output logic            done_timeout,
  output logic [NCS-1:0]  mem_cs_n,
  output logic [BW-1:0]   mem_ba,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_data_o,
  input  logic [DW-1:0]   mem_data_i,
  output logic            mem_data_oe,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  input  logic            mem_wait_n
);
  localparam int CNTW = (STBW > SETW) ? STBW : SETW;

  amc_state_e      state_q;
  logic [CNTW-1:0] cnt;
  logic            start, strobe_last, hold_last;
  logic            ws, wait_armed, ext_go, ext_done, ext_timeout;
  logic            op_wr_q, to_q, done_q;
  logic [CSW-1:0]  cs_q;
  logic [BW-1:0]   ba_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic [CNTW-1:0] setup_len, strobe_len, hold_len, turn_len;
  logic            strobe_end_evt;

  assign req_ready = (state_q == ST_IDLE);
  assign start     = req_valid && req_ready;

  // setup length is picked by the incoming request, the rest by the latched one
  assign setup_len  = req_write ? CNTW'(cfg_wr_setup)  : CNTW'(cfg_rd_setup);
  assign strobe_len = op_wr_q   ? CNTW'(cfg_wr_strobe) : CNTW'(cfg_rd_strobe);
  assign hold_len   = op_wr_q   ? CNTW'(cfg_wr_hold)   : CNTW'(cfg_rd_hold);
  assign turn_len   = CNTW'(cfg_turn);

  amc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(~mem_wait_n), .q(ws)
  );

  amc_seq #(.CNTW(CNTW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .setup_len(setup_len), .strobe_len(strobe_len), .hold_len(hold_len), .turn_len(turn_len),
    .ext_go(ext_go), .ext_done(ext_done),
    .state(state_q), .cnt(cnt), .strobe_last(strobe_last), .hold_last(hold_last)
  );

  amc_wait #(.CNTW(CNTW), .MWW(MWW), .LEAD(WAIT_LEAD)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(start), .ws(ws), .state(state_q), .cnt(cnt),
    .strobe_last(strobe_last), .wait_max(cfg_wait_max),
    .armed(wait_armed), .ext_go(ext_go), .ext_done(ext_done), .ext_timeout(ext_timeout)
  );

  // last cycle with a strobe low: the nominal end without extension, or the extension end
  assign strobe_end_evt = (strobe_last && !ext_go) || ext_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      cs_q    <= '0;
      ba_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (start) begin
        op_wr_q <= req_write;
        cs_q    <= req_cs;
        ba_q    <= req_ba;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        to_q    <= 1'b0;
      end else if (ext_timeout) begin
        to_q <= 1'b1;
      end
      if (strobe_end_evt && !op_wr_q) rdata_q <= mem_data_i;
      done_q <= hold_last;
    end
  end

  always_comb begin
    mem_cs_n = '1;
    if (in_access(state_q)) mem_cs_n[cs_q] = 1'b0;
  end

  assign mem_ba       = ba_q;
  assign mem_addr     = addr_q;
  assign mem_data_o   = wdata_q;
  assign mem_data_oe  = in_access(state_q) && op_wr_q;
  assign mem_we_n     = !(in_strobe(state_q) && op_wr_q);
  assign mem_oe_n     = !(in_strobe(state_q) && !op_wr_q);
  assign done         = done_q;
  assign done_rdata   = rdata_q;
  assign done_timeout = done_q && to_q;
endmodule

// File: rtl/amc_ctrl_chk.sv
module amc_ctrl_chk
  import amc_pkg::*;
#(
  parameter int NCS = 2,
  parameter int AW  = 22
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           done,
  input logic           done_timeout,
  input logic [NCS-1:0] mem_cs_n,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_data_oe,
  input amc_state_e     state_q,
  input logic           wait_armed
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_data_oe);

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_cs_n) && !$past(&mem_cs_n)) |-> $stable(mem_addr));

  a_r4_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  a_r10_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_timeout |-> done);

  a_r8_ext_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXTW && $past(state_q) == ST_STROBE) |-> $past(wait_armed));
endmodule

bind amc_ctrl amc_ctrl_chk #(.NCS(NCS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .done_timeout(done_timeout),
  .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_data_oe(mem_data_oe), .state_q(state_q), .wait_armed(wait_armed)
);

// File: tb/amc_ctrl_tb_top.sv
module amc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  cfg_rd_setup = '0, cfg_wr_setup = '0;
  logic [5:0]  cfg_rd_strobe = '0, cfg_wr_strobe = '0;
  logic [2:0]  cfg_rd_hold = '0, cfg_wr_hold = '0;
  logic [1:0]  cfg_turn = '0;
  logic [7:0]  cfg_wait_max = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [0:0]  req_cs = '0;
  logic [1:0]  req_ba = '0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0, mem_data_i = '0;
  logic        mem_wait_n = 1'b1;
  logic        req_ready, done, done_timeout, mem_data_oe, mem_we_n, mem_oe_n;
  logic [15:0] done_rdata, mem_data_o;
  logic [1:0]  mem_cs_n, mem_ba;
  logic [21:0] mem_addr;

  amc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_turn(cfg_turn), .cfg_wait_max(cfg_wait_max),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
    .req_ba(req_ba), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .done_rdata(done_rdata), .done_timeout(done_timeout),
    .mem_cs_n(mem_cs_n), .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_data_o(mem_data_o),
    .mem_data_i(mem_data_i), .mem_data_oe(mem_data_oe), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_wait_n(mem_wait_n)
  );

  typedef struct packed {
    bit       wr;
    bit       cs;
    bit [3:0] su;
    bit [5:0] st;
    bit [2:0] hd;
    bit [1:0] ta;
    int       won;   // strobe cycle index where wait goes low (negative: before the request)
    int       woff;  // strobe cycle index where wait goes high again
    bit [7:0] mx;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd0,  6'd0,  3'd0, 2'd0,  999,  999, 8'd0},
    '{1'b1, 1'b1, 4'd15, 6'd5,  3'd7, 2'd3,  999,  999, 8'd0},
    '{1'b0, 1'b1, 4'd2,  6'd63, 3'd1, 2'd1,  999,  999, 8'd0},
    '{1'b0, 1'b0, 4'd1,  6'd6,  3'd2, 2'd0, -100,    8, 8'd10},
    '{1'b1, 1'b0, 4'd1,  6'd4,  3'd1, 2'd2, -100,  999, 8'd3},
    '{1'b0, 1'b1, 4'd3,  6'd2,  3'd0, 2'd0, -100,  999, 8'd5},
    '{1'b0, 1'b0, 4'd1,  6'd8,  3'd1, 2'd1,    4,  999, 8'd5},
    '{1'b0, 1'b1, 4'd1,  6'd8,  3'd1, 2'd1,    3,  999, 8'd0},
    '{1'b1, 1'b1, 4'd2,  6'd7,  3'd3, 2'd0, -100,    3, 8'd9},
    '{1'b0, 1'b0, 4'd0,  6'd3,  3'd0, 2'd0, -100,   20, 8'd255},
    '{1'b0, 1'b1, 4'd0,  6'd3,  3'd0, 2'd3, -100,  999, 8'd255}
  };

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fdat(int n);
    return 16'(n * 41 + 23130);
  endfunction

  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

  // synchronized wait is low in strobe cycles [won+2, woff+1]
  function automatic bit is_armed(int st, int won, int woff);
    if (st < 3) return 1'b0;
    return imax(won + 2, 0) <= imin(woff + 1, st - 3);
  endfunction

  function automatic int exp_ext(int st, int won, int woff, int mx);
    if (!is_armed(st, won, woff)) return 0;
    if (!((won + 2 <= st) && (st <= woff + 1))) return 0;
    return imin(woff + 1 - st, mx) + 1;
  endfunction

  task automatic run_vec(int idx);
    vec_t v;
    int su, st, hd, ta, ext, n, c;
    int cnt_su, cnt_st, cnt_hd, cnt_ta, cnt_done, err_cs, err_oe, err_other;
    bit seen_st, seen_done, got_to, exp_to;
    logic [15:0] got_rd, wd;
    logic [21:0] ad;
    string sreq;
    v = VECS[idx];
    su = int'(v.su); st = int'(v.st); hd = int'(v.hd); ta = int'(v.ta);
    ext = exp_ext(st, v.won, v.woff, int'(v.mx));
    exp_to = (ext > 0) && ((v.woff + 1 - st) > int'(v.mx));
    wd = 16'(16'h3C00 + idx * 16'h0111);
    ad = 22'(22'h2A5000 + idx * 22'h1357);
    // the unused direction gets different timing to show the fields are separate
    if (v.wr) begin
      cfg_wr_setup = v.su; cfg_wr_strobe = v.st; cfg_wr_hold = v.hd;
      cfg_rd_setup = ~v.su; cfg_rd_strobe = ~v.st; cfg_rd_hold = ~v.hd;
    end else begin
      cfg_rd_setup = v.su; cfg_rd_strobe = v.st; cfg_rd_hold = v.hd;
      cfg_wr_setup = ~v.su; cfg_wr_strobe = ~v.st; cfg_wr_hold = ~v.hd;
    end
    cfg_turn = v.ta; cfg_wait_max = v.mx;
    @(negedge clk);
    check(req_ready == 1'b1, "R5 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = v.wr; req_cs = v.cs; req_ba = 2'(idx);
    req_addr = ad; req_wdata = wd;
    mem_wait_n = (v.won < 0) ? 1'b0 : 1'b1;
    cnt_su = 0; cnt_st = 0; cnt_hd = 0; cnt_ta = 0; cnt_done = 0;
    err_cs = 0; err_oe = 0; err_other = 0;
    seen_st = 0; seen_done = 0; got_to = 0; got_rd = '0;
    n = 0;
    while (!(seen_done && req_ready) && n < 2000) begin
      @(negedge clk);
      req_valid = 1'b0;
      c = n - (su + 1);
      mem_wait_n = !((c >= v.won) && (c < v.woff));
      mem_data_i = fdat(n);
      if (mem_cs_n != 2'b11) begin
        if (mem_cs_n != ~(2'b01 << v.cs) || mem_addr != ad || mem_ba != 2'(idx)) err_cs++;
        if ((v.wr ? !mem_we_n : !mem_oe_n)) begin cnt_st++; seen_st = 1; end
        else if (!seen_st) cnt_su++;
        else cnt_hd++;
      end
      if ((v.wr ? !mem_oe_n : !mem_we_n)) err_other++;
      if (mem_data_oe != (v.wr && mem_cs_n != 2'b11)) err_oe++;
      if (mem_data_oe && mem_data_o != wd) err_oe++;
      if (done) begin
        cnt_done++; seen_done = 1; got_to = done_timeout; got_rd = done_rdata;
      end
      if (seen_done && !req_ready) cnt_ta++;
      n++;
    end
    mem_wait_n = 1'b1;
    check(cnt_su == su + 1, "R2 setup length", cnt_su, su + 1);
    check(err_cs == 0, "R2 chip select and address", err_cs, 0);
    if (ext > 0) sreq = exp_to ? "R10 strobe with ceiling" : "R9 extended strobe";
    else if (v.won < 500) sreq = "R8 wait without effect";
    else sreq = "R3 strobe length";
    check(cnt_st == st + 1 + ext, sreq, cnt_st, st + 1 + ext);
    check(err_other == 0, "R3 other strobe stays high", err_other, 0);
    check(cnt_hd == hd + 1, "R4 hold length", cnt_hd, hd + 1);
    check(cnt_done == 1, "R5 done pulse count", cnt_done, 1);
    check(cnt_ta == ta + 1, "R5 turnaround length", cnt_ta, ta + 1);
    check(err_oe == 0, "R7 data drive enable", err_oe, 0);
    check(got_to == exp_to, "R10 timeout flag", int'(got_to), int'(exp_to));
    if (!v.wr)
      check(got_rd == fdat(su + 1 + st + ext), "R6 read data capture",
            int'(got_rd), int'(fdat(su + 1 + st + ext)));
    repeat (2) @(negedge clk);
  endtask

  task automatic check_idle(string tag);
    check(mem_cs_n == 2'b11, tag, int'(mem_cs_n), 3);
    check(mem_we_n && mem_oe_n, tag, int'({mem_we_n, mem_oe_n}), 3);
    check(!mem_data_oe && !done, tag, int'({mem_data_oe, done}), 0);
    check(req_ready == 1'b1, tag, int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 idle during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");

    for (int i = 0; i < NV; i++) run_vec(i);

    // reset in the middle of a long read strobe
    cfg_rd_setup = 4'd0; cfg_rd_strobe = 6'd40; cfg_rd_hold = 3'd0; cfg_turn = 2'd0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_cs = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(mem_oe_n == 1'b0, "R3 strobe active before reset", int'(mem_oe_n), 0);
    rst_n = 1'b0;
    #1;
    check_idle("R1 idle after reset mid-access");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 idle after reset release");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule